// File: doc/BRIEF.md
# Fault-Triggered Smart Shutdown Sequencer

This block sequences the fault shutdown of a half-bridge gate driver that shares one open-drain shutdown line with its controller. A fault comparator trip masks both gate outputs at once, through a short synchronizer, without waiting for the slow external RC network on the shared line to discharge. At the same time the block drives the open-drain pull-down. It releases the pull-down once the line is seen below its lower logic threshold, so the external pull-up can recharge the line. Gates come back only when the line climbs past the upper threshold. A long RC constant therefore stretches the disable time without adding any delay to the protection.

Two digitized flags give the level of the shared line: below the lower threshold and above the upper threshold. A third flag reports supply undervoltage lockout. A shutdown driven onto the line from outside is not latched, so the controller can chop PWM through that line. A status output tells the controller whether the most recent shutdown came from an internal trip or from an external drive of the line.

Top module: `smart_shutdown_seq`

## Requirements
- R1: After reset, `pulldown_o` is 0, `gate_en_o` is 0 (line level unknown until the line is seen high) and `trip_src_o` is 0.
- R2: `trip_i` passes through a two-stage synchronizer. Once the synchronized trip is 1 and `uv_i` is 0, `gate_en_o` is 0 in that same cycle, whatever the line flags say. A trip held high keeps the gates masked but starts no second sequence.
- R3: A rising edge of the synchronized trip, with `uv_i` at 0 and the sequencer idle, asserts `pulldown_o` one cycle after the gates are masked.
- R4: `pulldown_o` stays 1 until `line_low_i` is sampled at 1, and it is 0 from the next clock edge on.
- R5: After the pull-down is released, `gate_en_o` stays 0 until `line_high_i` is sampled at 1. It is then 1 from the next edge, provided the synchronized trip is low.
- R6: With no trip, `line_low_i` disables the gates from the next edge and `line_high_i` enables them again from the next edge. Between the two thresholds the previous state is kept. `pulldown_o` is never asserted in this case.
- R7: While `uv_i` is 1, trips start no pull-down and `gate_en_o` is 0.
- R8: A new trip edge while the sequencer waits for the line to recover re-enters the pull-down state. It wins over `line_high_i` in the same cycle.
- R9: `trip_src_o` becomes 1 when a trip starts a pull-down sequence. It becomes 0 when `line_low_i` is seen while the sequencer is idle (external shutdown). Otherwise it holds its value.
- R10: If `line_low_i` and `line_high_i` are both 1, the line is treated as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trip_i | input | 1 | Fault comparator output, asynchronous |
| line_low_i | input | 1 | Shared line below lower logic threshold |
| line_high_i | input | 1 | Shared line above upper logic threshold |
| uv_i | input | 1 | Supply undervoltage lockout active |
| pulldown_o | output | 1 | Open-drain pull-down enable |
| gate_en_o | output | 1 | Gate enable mask to the deadtime controller |
| trip_src_o | output | 1 | 1: last shutdown from internal trip, 0: from external line drive |

## Verification
A new trip edge and the line crossing the upper threshold can fall in the same cycle while the sequencer waits for recovery. In that case re-entry into the pull-down state must win, and the gates must stay masked. The bench provokes this with a directed case: it releases the trip, lets the line reach the waiting state, then raises the trip two cycles before asserting the high flag, so that the synchronized edge and the flag line up. Random runs let a bench RC model of the line collide with random trips many more times. In both kinds of run, every cycle is judged against a cycle model that the bench computes from the requirements.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PULL = 2'd1,
    ST_WAIT = 2'd2
  } ssd_state_e;
endpackage

// File: rtl/ssd_sync.sv
module ssd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_single
      logic r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= 1'b0;
        else         r_q <= d_i;
      end
      assign q_o = r_q;
    end else begin : g_chain
      logic [STAGES-1:0] r_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= {r_q[STAGES-2:0], d_i};
      end
      assign q_o = r_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/ssd_line_hyst.sv
module ssd_line_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  input  logic high_i,
  output logic ok_o
);
  logic ok_q;

  // low wins over high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ok_q <= 1'b0;
    else if (low_i)  ok_q <= 1'b0;
    else if (high_i) ok_q <= 1'b1;
  end

  assign ok_o = ok_q;

  p_low_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_i |=> !ok_o);
  p_high_sets_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (high_i && !low_i) |=> ok_o);
endmodule

// File: rtl/ssd_fsm.sv
module ssd_fsm
  import ssd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_s_i,
  input  logic uv_i,
  input  logic line_low_i,
  input  logic line_high_i,
  output logic idle_o,
  output logic pulldown_o,
  output logic src_o
);
  ssd_state_e state_q, state_d;
  logic trip_d_q, rise_ok, src_q;

  assign rise_ok = trip_s_i & ~trip_d_q & ~uv_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (rise_ok) state_d = ST_PULL;
      ST_PULL: if (line_low_i) state_d = ST_WAIT;
      ST_WAIT: begin
        if (rise_ok)          state_d = ST_PULL;
        else if (line_high_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      trip_d_q <= 1'b0;
      src_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      trip_d_q <= trip_s_i;
      if (state_d == ST_PULL && state_q != ST_PULL)
        src_q <= 1'b1;
      else if (state_q == ST_IDLE && line_low_i)
        src_q <= 1'b0;
    end
  end

  assign idle_o     = (state_q == ST_IDLE);
  assign pulldown_o = (state_q == ST_PULL);
  assign src_o      = src_q;

  p_enter_pull_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && rise_ok) |=> pulldown_o);
  p_hold_pull_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulldown_o && !line_low_i) |=> pulldown_o);
  p_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulldown_o && line_low_i) |=> !pulldown_o);
  p_reenter_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && rise_ok) |=> pulldown_o);
  p_src_trip_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulldown_o) |-> src_o);
  p_uv_no_pull_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_i && state_q == ST_IDLE) |=> !pulldown_o);
endmodule

// File: rtl/smart_shutdown_seq.sv
module smart_shutdown_seq #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic line_low_i,
  input  logic line_high_i,
  input  logic uv_i,
  output logic pulldown_o,
  output logic gate_en_o,
  output logic trip_src_o
);
  logic trip_s, line_ok, idle, trip_act;

  ssd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trip_i),
    .q_o   (trip_s)
  );

  ssd_line_hyst u_hyst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .low_i (line_low_i),
    .high_i(line_high_i),
    .ok_o  (line_ok)
  );

  ssd_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trip_s_i   (trip_s),
    .uv_i       (uv_i),
    .line_low_i (line_low_i),
    .line_high_i(line_high_i),
    .idle_o     (idle),
    .pulldown_o (pulldown_o),
    .src_o      (trip_src_o)
  );

  // fast path: mask straight from the synchronized trip
  assign trip_act  = trip_s & ~uv_i;
  assign gate_en_o = line_ok & idle & ~trip_act & ~uv_i;

  p_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_s && !uv_i) |-> !gate_en_o);
  p_uv_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> !gate_en_o);
  p_pull_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulldown_o |-> !gate_en_o);
  p_ext_no_pull_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trip_s && !pulldown_o) |=> !$rose(pulldown_o) || $past(trip_s) || trip_s);
endmodule

// File: tb/smart_shutdown_seq_bench.sv
module smart_shutdown_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trip = 1'b0, lo = 1'b0, hi = 1'b0, uv = 1'b0;
  logic pd, gate, src;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  // reference model
  logic m_s1 = 1'b0, m_s2 = 1'b0, m_d = 1'b0, m_ok = 1'b0, m_src = 1'b0;
  int m_state = 0;  // 0 idle, 1 pulling, 2 waiting

  always #4 clk = ~clk;

  smart_shutdown_seq u_smart_shutdown_seq (
    .clk_i(clk), .rst_ni(rst_n), .trip_i(trip), .line_low_i(lo),
    .line_high_i(hi), .uv_i(uv), .pulldown_o(pd), .gate_en_o(gate),
    .trip_src_o(trip_src_o_w)
  );
  logic trip_src_o_w;
  assign src = trip_src_o_w;

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%0b exp=%0b t=%0t", req, what, got, exp, $time);
    end
  endtask

  function automatic logic exp_gate();
    return m_ok && m_state == 0 && !m_s2 && !uv;
  endfunction

  // drive at negedge, advance model at posedge, compare at next negedge
  task automatic step(input logic t, input logic l, input logic h, input logic u);
    logic rise;
    int ns;
    trip = t; lo = l; hi = h; uv = u;
    @(posedge clk);
    rise = m_s2 && !m_d && !u;
    ns = m_state;
    case (m_state)
      0: if (rise) ns = 1;
      1: if (l) ns = 2;
      default: if (rise) ns = 1; else if (h) ns = 0;
    endcase
    if (ns == 1 && m_state != 1) m_src = 1'b1;
    else if (m_state == 0 && l)  m_src = 1'b0;
    if (l) m_ok = 1'b0; else if (h) m_ok = 1'b1;
    m_state = ns;
    m_d = m_s2; m_s2 = m_s1; m_s1 = t;
    @(negedge clk);
    chk(cur_req, "pulldown", pd, m_state == 1);
    chk(cur_req, "gate_en", gate, exp_gate());
    chk(cur_req, "trip_src", src, m_src);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "pulldown", pd, 1'b0);
    chk("R1", "gate_en", gate, 1'b0);
    chk("R1", "trip_src", src, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 external drive, PWM chopping, hysteresis hold
    cur_req = "R6";
    step(0, 0, 1, 0);
    chk("R6", "gate on after high", gate, 1'b1);
    step(0, 1, 0, 0);
    chk("R6", "gate off after low", gate, 1'b0);
    step(0, 0, 0, 0);
    chk("R6", "hold low between thresholds", gate, 1'b0);
    step(0, 0, 1, 0);
    step(0, 0, 0, 0);
    chk("R6", "hold high between thresholds", gate, 1'b1);
    for (int i = 0; i < 6; i++) step(0, i[0], !i[0], 0);
    chk("R9", "external shutdown source", src, 1'b0);

    // R2 R3 R4 R5 trip sequence, line stays mid
    cur_req = "R2";
    step(0, 0, 1, 0);
    step(1, 0, 0, 0);
    chk("R2", "not yet masked after one stage", gate, 1'b1);
    step(1, 0, 0, 0);
    chk("R2", "masked before line falls", gate, 1'b0);
    chk("R3", "pulldown not before mask cycle", pd, 1'b0);
    cur_req = "R3";
    step(1, 0, 0, 0);
    chk("R3", "pulldown asserted", pd, 1'b1);
    chk("R9", "trip source", src, 1'b1);
    cur_req = "R4";
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0);
    chk("R4", "pulldown held above low", pd, 1'b1);
    step(0, 1, 0, 0);
    chk("R4", "pulldown released", pd, 1'b0);
    cur_req = "R5";
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
    chk("R5", "gate waits for high", gate, 1'b0);
    step(0, 0, 1, 0);
    chk("R5", "gate resumes", gate, 1'b1);
    chk("R9", "source holds after recovery", src, 1'b1);

    // R8 trip edge meets line high in wait state
    cur_req = "R8";
    step(1, 0, 0, 0); step(1, 0, 0, 0); step(0, 0, 0, 0);
    step(0, 1, 0, 0);
    step(1, 0, 0, 0);
    step(1, 0, 0, 0);
    chk("R8", "masked before collision", gate, 1'b0);
    step(1, 0, 1, 0);
    chk("R8", "re-entered pulldown", pd, 1'b1);
    chk("R8", "gate stays off", gate, 1'b0);
    step(1, 1, 0, 0); step(1, 0, 1, 0);
    chk("R2", "held trip keeps mask", gate, 1'b0);
    chk("R2", "held trip no second pull", pd, 1'b0);
    step(0, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 1, 0);

    // R7 undervoltage
    cur_req = "R7";
    step(1, 0, 0, 1); step(1, 0, 0, 1); step(1, 0, 0, 1);
    chk("R7", "no pulldown in uv", pd, 1'b0);
    chk("R7", "gate off in uv", gate, 1'b0);
    step(0, 0, 0, 1); step(0, 0, 0, 0);

    // R10 both flags set
    cur_req = "R10";
    step(0, 0, 1, 0);
    step(0, 1, 1, 0);
    chk("R10", "both flags read as low", gate, 1'b0);
    step(0, 0, 1, 0);

    // random: RC line model with external force, trips, rare uv
    cur_req = "R4/R5/R9 random";
    v = 100;
    for (int i = 0; i < 4000; i++) begin
      logic t, f, u;
      f = ($urandom % 100) < 4;
      t = ($urandom % 100) < 3 ? 1'b1 : (trip && ($urandom % 100) < 70);
      u = ($urandom % 100) < 2;
      if (pd || f) v = (v > 12) ? v - 12 : 0;
      else         v = (v < 97) ? v + 1 + ($urandom % 3) : 100;
      step(t, v < 30, v > 70, u);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule